// File: doc/BRIEF.md
# Vectored 64-Source Interrupt Controller

This block gathers 64 interrupt request inputs and presents them to a processor through a small 32-bit register bus. Every source owns one control byte that switches it on, picks how it triggers (active-high level, rising edge, falling edge or both edges) and routes it to one of eight destinations: the normal interrupt line, the fast interrupt line, or one of six auxiliary lines. Edge events are caught in per-source flags that software clears by writing ones into a status word. Level sources show the live input gated by their enable.

For the two processor-facing destinations the block also works out which pending source should be served next. Reading a destination's priority register returns that source number. Priority is either fixed (lowest number wins) or rotating, where the search starts just past the source returned by the previous read of that register. With nothing pending the index reads 63, and software separates that from a real source 63 by checking the top bit of the upper status word. Inputs are expected to be synchronous to the block clock already.

Top module: `vec_intc`

## Requirements
- R1: While and after reset every control byte is 0 (all sources off, routed to the normal line), the status words read 0, all destination lines are low and both priority registers read 0x0000003F.
- R2: Source n's control byte lives at byte address 0x40+n (word 0x40+4*(n/4), lane n%4) and reads back as written; its bits are [2:0] destination, [3] enable, [5] rising edge, [6] falling edge.
- R3: With bits 5 and 6 both clear, a source is an active-high level source: its status bit equals input AND enable, and writing 1 to that status bit changes nothing.
- R4: With bit 5 and/or bit 6 set, an enabled source latches a status flag on the selected edge (input compared with its value one cycle earlier); the flag stays set after the input returns, writing 1 to its status bit clears it, and an edge in the same cycle as the clear leaves it set.
- R5: Destination code 0 drives irq_o, 1 drives fiq_o and codes 2..7 drive aux_o[0..5]; each line is a register holding the OR of the pending enabled sources routed to it, one cycle after that pending state.
- R6: The status word at 0x80 holds sources 0..31 and the word at 0x84 holds sources 32..63, source n at bit n%32.
- R7: A read of 0x20 (normal line) or 0x24 (fast line) returns in bits [5:0] the chosen pending source among those routed to that line, and 63 when none is pending; bit 6 returns the rotate setting.
- R8: With bit 6 of a priority register clear, the lowest-numbered pending source routed to that line is returned.
- R9: With bit 6 set, the search begins at the source just above the one returned by the previous read of that register (wrapping from 63 to 0; after reset it begins at 0).
- R10: Read data appears on bus_rdata one cycle after bus_rd; unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 64 | Interrupt request inputs, already synchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane write enables |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| aux_o | output | 6 | Auxiliary destination lines |

## Verification
On every cycle the assertions check that the normal and fast lines are the registered OR of their candidate sets, that any index the picker reports is really pending, that fixed mode never skips a lower pending source, that an idle priority read returns 63, and that reset clears the lines. Edge latching and its same-cycle clear, the write-1 immunity of level sources, the routing of all destination codes, the status word layout, the order of rotating reads and the source-63 ambiguity only show up through the bench's bus sequences.

// File: rtl/vi_pkg.sv
package vi_pkg;
  // Control byte of one source.
  typedef struct packed {
    logic       spare7;
    logic       on_fall;
    logic       on_rise;
    logic       spare4;
    logic       enable;
    logic [2:0] route;
  } vi_ctrl_t;

  localparam logic [7:0] PRIO_ADDR = 8'h20;  // +4 per picked destination
  localparam logic [7:0] CTRL_ADDR = 8'h40;
  localparam logic [7:0] STAT_ADDR = 8'h80;  // +4 per 32 sources
endpackage

// File: rtl/vi_src.sv
module vi_src
  import vi_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     req,
  input  vi_ctrl_t ctrl,
  input  logic     clr,
  output logic     pend
);
  logic prev_q, flag_q;
  logic is_edge, hit;

  assign is_edge = ctrl.on_rise | ctrl.on_fall;
  assign hit = ctrl.enable & ((ctrl.on_rise & req & ~prev_q) |
                              (ctrl.on_fall & ~req & prev_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= req;
      // a fresh edge beats a clear in the same cycle
      flag_q <= ctrl.enable & is_edge & (hit | (flag_q & ~clr));
    end
  end

  assign pend = is_edge ? flag_q : (ctrl.enable & req);
endmodule

// File: rtl/vi_pick.sv
module vi_pick #(
  parameter int SRC_N = 64,
  localparam int IW = $clog2(SRC_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] cand,
  input  logic             rotate,
  input  logic             take,
  output logic             any,
  output logic [IW-1:0]    idx
);
  logic [IW-1:0] last_q;
  int start;

  always_comb begin
    start = rotate ? (int'(last_q) + 1) % SRC_N : 0;
    any = 1'b0;
    idx = IW'(SRC_N - 1);
    // walk downwards so the smallest offset from start wins
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (cand[(start + i) % SRC_N]) begin
        any = 1'b1;
        idx = IW'((start + i) % SRC_N);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= IW'(SRC_N - 1);
    else if (take && any) last_q <= idx;
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vi_pkg::*;
#(
  parameter int SRC_N = 64,
  parameter int AUX_N = 6,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_N-1:0] src_in,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic [3:0]       bus_be,
  output logic [31:0]      bus_rdata,
  output logic             irq_o,
  output logic             fiq_o,
  output logic [AUX_N-1:0] aux_o
);
  localparam int IW    = $clog2(SRC_N);
  localparam int NWORD = SRC_N / 32;
  localparam int NDEST = AUX_N + 2;
  localparam int NPICK = 2;

  vi_ctrl_t ctrl_q [SRC_N];
  logic [SRC_N-1:0] clr_vec, pend;
  logic [NDEST-1:0][SRC_N-1:0] cand;
  logic [NDEST-1:0] line_q;
  logic [NPICK-1:0] rot_q, take, pick_any;
  logic [NPICK-1:0][IW-1:0] pick_idx;
  logic [SRC_N-1:0] irq_cand, fiq_cand;
  logic [IW-1:0] irq_pick, fiq_pick;
  logic [AW-1:0] ctrl_off;
  logic ctrl_sel;
  logic [31:0] rd_next;

  assign ctrl_off = bus_addr - AW'(CTRL_ADDR);
  assign ctrl_sel = (bus_addr >= AW'(CTRL_ADDR)) &&
                    (int'(bus_addr) < int'(CTRL_ADDR) + SRC_N);

  // control bytes, one write lane per source
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SRC_N; s++) ctrl_q[s] <= '0;
    end else if (bus_wr && ctrl_sel) begin
      for (int l = 0; l < 4; l++)
        if (bus_be[l]) ctrl_q[(int'(ctrl_off) & ~3) + l] <= bus_wdata[8*l +: 8];
    end
  end

  // write-one-to-clear strobes for the status words
  always_comb begin
    clr_vec = '0;
    for (int w = 0; w < NWORD; w++)
      if (bus_wr && bus_addr == AW'(int'(STAT_ADDR) + 4*w))
        for (int b = 0; b < 32; b++)
          clr_vec[32*w + b] = bus_wdata[b] & bus_be[b/8];
  end

  for (genvar s = 0; s < SRC_N; s++) begin : g_src
    vi_src u_src (
      .clk (clk),
      .rst (rst),
      .req (src_in[s]),
      .ctrl(ctrl_q[s]),
      .clr (clr_vec[s]),
      .pend(pend[s])
    );
    for (genvar d = 0; d < NDEST; d++) begin : g_route
      assign cand[d][s] = pend[s] && (int'(ctrl_q[s].route) == d);
    end
  end

  for (genvar d = 0; d < NDEST; d++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) line_q[d] <= 1'b0;
      else     line_q[d] <= |cand[d];
    end
  end

  assign irq_o = line_q[0];
  assign fiq_o = line_q[1];
  assign aux_o = line_q[NDEST-1:2];

  for (genvar p = 0; p < NPICK; p++) begin : g_pick
    assign take[p] = bus_rd && bus_addr == AW'(int'(PRIO_ADDR) + 4*p);
    always_ff @(posedge clk) begin
      if (rst) rot_q[p] <= 1'b0;
      else if (bus_wr && bus_be[0] && bus_addr == AW'(int'(PRIO_ADDR) + 4*p))
        rot_q[p] <= bus_wdata[6];
    end
    vi_pick #(.SRC_N(SRC_N)) u_pick (
      .clk   (clk),
      .rst   (rst),
      .cand  (cand[p]),
      .rotate(rot_q[p]),
      .take  (take[p]),
      .any   (pick_any[p]),
      .idx   (pick_idx[p])
    );
  end

  assign irq_cand = cand[0];
  assign fiq_cand = cand[1];
  assign irq_pick = pick_idx[0];
  assign fiq_pick = pick_idx[1];

  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NPICK; p++)
      if (bus_addr == AW'(int'(PRIO_ADDR) + 4*p))
        rd_next = {25'd0, rot_q[p], 6'(pick_idx[p])};
    for (int w = 0; w < NWORD; w++)
      if (bus_addr == AW'(int'(STAT_ADDR) + 4*w))
        rd_next = pend[32*w +: 32];
    if (ctrl_sel)
      for (int l = 0; l < 4; l++)
        rd_next[8*l +: 8] = ctrl_q[(int'(ctrl_off) & ~3) + l];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
  parameter int SRC_N = 64,
  parameter int AUX_N = 6,
  parameter int AW    = 8,
  localparam int IW = $clog2(SRC_N)
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_rd,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_rdata,
  input logic             irq_o,
  input logic             fiq_o,
  input logic [AUX_N-1:0] aux_o,
  input logic [SRC_N-1:0] irq_cand,
  input logic [SRC_N-1:0] fiq_cand,
  input logic [1:0]       pick_any,
  input logic [1:0]       rot_q,
  input logic [IW-1:0]    irq_pick,
  input logic [IW-1:0]    fiq_pick
);
  a_r1_reset_lines: assert property (@(posedge clk)
    rst |=> (!irq_o && !fiq_o && aux_o == '0));

  a_r5_irq_registered: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_o == $past(|irq_cand));

  a_r5_fiq_registered: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> fiq_o == $past(|fiq_cand));

  a_r7_idle_reads_63: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == AW'(8'h20) && irq_cand == '0) |=> bus_rdata[5:0] == 6'h3F);

  a_r7_irq_pick_pending: assert property (@(posedge clk) disable iff (rst)
    pick_any[0] |-> irq_cand[irq_pick]);

  a_r7_fiq_pick_pending: assert property (@(posedge clk) disable iff (rst)
    pick_any[1] |-> fiq_cand[fiq_pick]);

  a_r8_fixed_lowest: assert property (@(posedge clk) disable iff (rst)
    (!rot_q[0] && pick_any[0]) |-> (irq_cand & ~({SRC_N{1'b1}} << irq_pick)) == '0);
endmodule

bind vec_intc vec_intc_chk #(.SRC_N(SRC_N), .AUX_N(AUX_N), .AW(AW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .aux_o    (aux_o),
  .irq_cand (irq_cand),
  .fiq_cand (fiq_cand),
  .pick_any (pick_any),
  .rot_q    (rot_q),
  .irq_pick (irq_pick),
  .fiq_pick (fiq_pick)
);

// File: tb/vec_intc_tb.sv
module vec_intc_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [63:0] src_in = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_rdata;
  logic irq_o, fiq_o;
  logic [5:0] aux_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  vec_intc dut_i (
    .clk(clk), .rst(rst), .src_in(src_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o), .aux_o(aux_o)
  );

  // {source, control byte, expected {aux[5:0], fiq, irq}}
  localparam logic [23:0] VEC [8] = '{
    {8'd5,  8'h08, 8'h01},
    {8'd12, 8'h09, 8'h02},
    {8'd40, 8'h0A, 8'h04},
    {8'd33, 8'h0B, 8'h08},
    {8'd20, 8'h0C, 8'h10},
    {8'd50, 8'h0E, 8'h40},
    {8'd63, 8'h0F, 8'h80},
    {8'd0,  8'h00, 8'h00}
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_ctrl(input int s, input logic [7:0] c);
    wr(8'h40 + 8'(s & ~3), 32'(c) << (8 * (s % 4)), 4'b0001 << (s % 4));
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle(1);
    // R1 reset state
    check({aux_o, fiq_o, irq_o} == 8'h00, "R1 lines", 32'({aux_o, fiq_o, irq_o}), 0);
    rd(8'h40, rv); check(rv == 0, "R1 ctrl", rv, 0);
    rd(8'h84, rv); check(rv == 0, "R1 status", rv, 0);
    rd(8'h20, rv); check(rv == 32'h3F, "R1 prio", rv, 32'h3F);
    rd(8'h24, rv); check(rv == 32'h3F, "R1 fprio", rv, 32'h3F);
    // R10 unmapped address
    rd(8'h10, rv); check(rv == 0, "R10 unmapped", rv, 0);

    // R2 control byte readback in lane 2 of word 0x44
    set_ctrl(6, 8'h6B);
    rd(8'h44, rv); check(rv == 32'h006B0000, "R2 readback", rv, 32'h006B0000);
    set_ctrl(6, 8'h00);

    // routing table walk: R5, R6, R7
    for (int e = 0; e < 8; e++) begin
      int s;
      logic [7:0] c, ex;
      logic [31:0] ei, ef;
      s = int'(VEC[e][23:16]); c = VEC[e][15:8]; ex = VEC[e][7:0];
      set_ctrl(s, c);
      src_in[s] = 1'b1;
      settle(2);
      check({aux_o, fiq_o, irq_o} == ex, "R5 route", 32'({aux_o, fiq_o, irq_o}), 32'(ex));
      rd(8'h80 + 8'(4 * (s / 32)), rv);
      check(rv[s % 32] == c[3], "R6 status bit", 32'(rv[s % 32]), 32'(c[3]));
      ei = (c[3] && c[2:0] == 3'd0) ? s : 63;
      ef = (c[3] && c[2:0] == 3'd1) ? s : 63;
      rd(8'h20, rv); check(rv[5:0] == ei[5:0], "R7 irq index", 32'(rv[5:0]), ei);
      rd(8'h24, rv); check(rv[5:0] == ef[5:0], "R7 fiq index", 32'(rv[5:0]), ef);
      src_in[s] = 1'b0;
      set_ctrl(s, 8'h00);
      settle(2);
    end

    // R7 source 63 vs nothing pending
    rd(8'h84, rv); check(rv[31] == 1'b0, "R7 idle bit31", rv, 0);
    set_ctrl(63, 8'h08); src_in[63] = 1'b1; settle(1);
    rd(8'h20, rv); check(rv[5:0] == 6'd63, "R7 real 63", rv, 63);
    rd(8'h84, rv); check(rv[31] == 1'b1, "R7 real bit31", rv, 32'h80000000);
    src_in[63] = 1'b0; set_ctrl(63, 8'h00);

    // R3 level source ignores write-1
    set_ctrl(7, 8'h08); src_in[7] = 1'b1; settle(1);
    wr(8'h80, 32'h80, 4'hF);
    rd(8'h80, rv); check(rv[7] == 1'b1, "R3 level write1", rv, 32'h80);
    src_in[7] = 1'b0; settle(1);
    rd(8'h80, rv); check(rv[7] == 1'b0, "R3 level follows", rv, 0);
    set_ctrl(7, 8'h00);

    // R4 rising edge latch, clear, same-cycle rearm
    set_ctrl(10, 8'h28);
    src_in[10] = 1'b1; settle(1); src_in[10] = 1'b0; settle(1);
    rd(8'h80, rv); check(rv[10] == 1'b1, "R4 edge latched", rv, 32'h400);
    wr(8'h80, 32'h400, 4'hF);
    rd(8'h80, rv); check(rv[10] == 1'b0, "R4 edge cleared", rv, 0);
    @(negedge clk);
    src_in[10] = 1'b1;
    bus_wr = 1'b1; bus_addr = 8'h80; bus_wdata = 32'h400; bus_be = 4'hF;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
    rd(8'h80, rv); check(rv[10] == 1'b1, "R4 edge beats clear", rv, 32'h400);
    wr(8'h80, 32'h400, 4'hF);
    src_in[10] = 1'b0;
    set_ctrl(10, 8'h00);

    // R4 falling edge on source 45 (status word 0x84 bit 13)
    src_in[45] = 1'b1; settle(1);
    set_ctrl(45, 8'h48); settle(1);
    rd(8'h84, rv); check(rv[13] == 1'b0, "R4 no fall yet", rv, 0);
    src_in[45] = 1'b0; settle(1);
    rd(8'h84, rv); check(rv[13] == 1'b1, "R4 fall latched", rv, 32'h2000);
    set_ctrl(45, 8'h00);

    // R8 fixed and R9 rotating priority on sources 2, 5, 9
    set_ctrl(2, 8'h08); set_ctrl(5, 8'h08); set_ctrl(9, 8'h08);
    src_in[2] = 1'b1; src_in[5] = 1'b1; src_in[9] = 1'b1; settle(1);
    rd(8'h20, rv); check(rv[5:0] == 6'd2, "R8 fixed first", rv, 2);
    rd(8'h20, rv); check(rv[5:0] == 6'd2, "R8 fixed repeat", rv, 2);
    wr(8'h20, 32'h40, 4'h1);
    rd(8'h20, rv); check(rv[6:0] == 7'h45, "R9 rotate 5", rv, 32'h45);
    rd(8'h20, rv); check(rv[5:0] == 6'd9, "R9 rotate 9", rv, 9);
    rd(8'h20, rv); check(rv[5:0] == 6'd2, "R9 rotate wrap", rv, 2);
    wr(8'h20, 32'h00, 4'h1);
    rd(8'h20, rv); check(rv[6:0] == 7'd2, "R8 back to fixed", rv, 2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule